// File: doc/BRIEF.md
# Address Decode Window Unit

This unit holds a bank of programmable windows that steer CPU physical addresses toward on-chip devices. Every window has a control word and a base word. The low-numbered windows also carry a pair of remap words. Software programs these words through a simple 32-bit register port. Each window names a 4-bit target ID and an 8-bit attribute for the device behind it. It also covers a range of the 36-bit physical space, sized in multiples of 64 KiB.

On each lookup the unit searches for an enabled window that contains the presented address. One clock later it returns a hit flag, the target and attribute of that window, and the address the device should see. That address is relocated for windows that can remap and left alone for windows that cannot. Register reads are combinational. Writes take effect at the clock edge.

Top module: `addr_window_unit`

## Requirements
- R1: After reset every register reads as zero, `res_valid` is low, and no lookup hits.
- R2: Control word layout: bit 0 is enable, bits 7:4 are the target ID, bits 15:8 are the attribute, and bits 31:16 hold the window size minus one in 64 KiB granules. Bits 3:1 read as zero.
- R3: Base word layout: bits 31:16 hold physical address bits 31:16, and bits 3:0 hold physical address bits 35:32. All other bits read as zero.
- R4: Register map (byte addresses; bits 1:0 are ignored):
  - Window w below 8 sits at w×16, with control at +0, base at +4, remap-low at +8 and remap-high at +12.
  - Window w from 8 to 19 sits at 0x90+(w−8)×8, with control at +0 and base at +4.
- R5: Remap-low keeps only bits 31:16, which supply remap address bits 31:16; its bits 15:0 read as zero. Remap-high keeps only bits 3:0, which supply remap address bits 35:32.
- R6: Byte addresses 0x80–0x8F and 0xF0–0xFF read as zero. Writes to them change no register.
- R7: A window hits when it is enabled and base ≤ address < base + size. A disabled window never hits.
- R8: When several enabled windows hit, the lowest-numbered one supplies the result.
- R9: A hit in a window numbered below 8 returns remap + (address − base).
- R10: A hit in a window numbered 8 or above returns the address unchanged.
- R11: A miss returns `res_hit` low, target and attribute zero, and the address unchanged.
- R12: `res_valid` is high in exactly the cycle after each cycle with `lk_valid` high. The result fields belong to that lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 36 | Physical address to decode |
| res_valid | output | 1 | Lookup result valid |
| res_hit | output | 1 | A window matched |
| res_tgt | output | 4 | Target ID of the matching window |
| res_attr | output | 8 | Attribute of the matching window |
| res_addr | output | 36 | Translated address |

## Verification
The bench builds the unit with its default parameters: 20 windows, 8 of them able to remap, and an 8-bit register address. With that setting it can reach both strides of the register map, the reserved hole between them, the unused tail after window 19, and the remap and pass-through paths. The same setting lets it place an overlapping remapping window and a non-remapping window over one range, to exercise priority and the effect of disabling a window. Window edges are checked one byte inside and one byte outside each range.

// File: rtl/adw_pkg.sv
package adw_pkg;
  localparam int GRAN_W = 16;
  localparam int PA_W   = 36;
  localparam int PG_W   = PA_W - GRAN_W;
  localparam int TGT_W  = 4;
  localparam int ATTR_W = 8;

  typedef struct packed {
    logic              en;
    logic [TGT_W-1:0]  tgt;
    logic [ATTR_W-1:0] attr;
    logic [GRAN_W-1:0] szm1;
    logic [PG_W-1:0]   base;
    logic [PG_W-1:0]   rmp;
  } win_t;

  // Word index (byte address / 4) of register r of window w.
  function automatic int word_idx(int w, int r, int nrm);
    if (w < nrm) return w * 4 + r;
    return nrm * 4 + 4 + (w - nrm) * 2 + r;
  endfunction
endpackage

// File: rtl/adw_regs.sv
module adw_regs
  import adw_pkg::*;
#(
  parameter int NUM_WIN   = 20,
  parameter int NUM_REMAP = 8,
  parameter int CFG_AW    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [CFG_AW-1:0]          cfg_addr,
  input  logic [31:0]                cfg_wdata,
  output logic [31:0]                cfg_rdata,
  output win_t [NUM_WIN-1:0]         wins
);
  localparam int WIDX_W = CFG_AW - 2;

  logic [WIDX_W-1:0] widx;
  logic              unused_lo;
  logic [NUM_WIN-1:0][31:0] rdw;

  assign widx      = cfg_addr[CFG_AW-1:2];
  assign unused_lo = ^cfg_addr[1:0];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    localparam int  CI    = word_idx(w, 0, NUM_REMAP);
    localparam bit  IS_RM = (w < NUM_REMAP);

    win_t cur, nxt;
    logic hit_c, hit_b, hit_rl, hit_rh;

    assign hit_c  = (widx == WIDX_W'(CI));
    assign hit_b  = (widx == WIDX_W'(CI + 1));
    assign hit_rl = IS_RM && (widx == WIDX_W'(CI + 2));
    assign hit_rh = IS_RM && (widx == WIDX_W'(CI + 3));

    always_comb begin
      nxt = cur;
      if (cfg_we && hit_c) begin
        nxt.en   = cfg_wdata[0];
        nxt.tgt  = cfg_wdata[7:4];
        nxt.attr = cfg_wdata[15:8];
        nxt.szm1 = cfg_wdata[31:16];
      end
      if (cfg_we && hit_b) begin
        nxt.base[GRAN_W-1:0]    = cfg_wdata[31:16];
        nxt.base[PG_W-1:GRAN_W] = cfg_wdata[3:0];
      end
      if (cfg_we && hit_rl) nxt.rmp[GRAN_W-1:0]    = cfg_wdata[31:16];
      if (cfg_we && hit_rh) nxt.rmp[PG_W-1:GRAN_W] = cfg_wdata[3:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cur <= '0;
      else        cur <= nxt;
    end

    always_comb begin
      rdw[w] = '0;
      if (hit_c)  rdw[w] = {cur.szm1, cur.attr, cur.tgt, 3'b000, cur.en};
      if (hit_b)  rdw[w] = {cur.base[GRAN_W-1:0], 12'h000, cur.base[PG_W-1:GRAN_W]};
      if (hit_rl) rdw[w] = {cur.rmp[GRAN_W-1:0], 16'h0000};
      if (hit_rh) rdw[w] = {28'h0, cur.rmp[PG_W-1:GRAN_W]};
    end

    assign wins[w] = cur;
  end

  always_comb begin
    cfg_rdata = '0;
    for (int w = 0; w < NUM_WIN; w++) cfg_rdata = cfg_rdata | rdw[w];
  end
endmodule

// File: rtl/adw_match.sv
module adw_match
  import adw_pkg::*;
#(
  parameter int NUM_WIN = 20
) (
  input  win_t [NUM_WIN-1:0]            wins,
  input  logic [PG_W-1:0]               ag,
  output logic [NUM_WIN-1:0]            hits,
  output logic [NUM_WIN-1:0][PG_W-1:0]  diffs
);
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
    assign diffs[w] = ag - wins[w].base;
    assign hits[w]  = wins[w].en && (ag >= wins[w].base) &&
                      (diffs[w] <= PG_W'(wins[w].szm1));
  end
endmodule

// File: rtl/adw_select.sv
module adw_select
  import adw_pkg::*;
#(
  parameter int NUM_WIN   = 20,
  parameter int NUM_REMAP = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          lk_valid,
  input  logic [PA_W-1:0]               lk_addr,
  input  win_t [NUM_WIN-1:0]            wins,
  input  logic [NUM_WIN-1:0]            hits,
  input  logic [NUM_WIN-1:0][PG_W-1:0]  diffs,
  output logic                          res_valid,
  output logic                          res_hit,
  output logic [TGT_W-1:0]              res_tgt,
  output logic [ATTR_W-1:0]             res_attr,
  output logic [PA_W-1:0]               res_addr
);
  logic              n_hit;
  logic [TGT_W-1:0]  n_tgt;
  logic [ATTR_W-1:0] n_attr;
  logic [PA_W-1:0]   n_addr;

  // Walk from the top so the lowest-numbered hit is applied last.
  always_comb begin
    n_hit  = 1'b0;
    n_tgt  = '0;
    n_attr = '0;
    n_addr = lk_addr;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (hits[w]) begin
        n_hit  = 1'b1;
        n_tgt  = wins[w].tgt;
        n_attr = wins[w].attr;
        if (w < NUM_REMAP) n_addr = {wins[w].rmp + diffs[w], lk_addr[GRAN_W-1:0]};
        else               n_addr = lk_addr;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_tgt   <= '0;
      res_attr  <= '0;
      res_addr  <= '0;
    end else begin
      res_valid <= lk_valid;
      if (lk_valid) begin
        res_hit  <= n_hit;
        res_tgt  <= n_tgt;
        res_attr <= n_attr;
        res_addr <= n_addr;
      end
    end
  end
endmodule

// File: rtl/addr_window_unit.sv
module addr_window_unit
  import adw_pkg::*;
#(
  parameter int NUM_WIN   = 20,
  parameter int NUM_REMAP = 8,
  parameter int CFG_AW    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              lk_valid,
  input  logic [35:0]       lk_addr,
  output logic              res_valid,
  output logic              res_hit,
  output logic [3:0]        res_tgt,
  output logic [7:0]        res_attr,
  output logic [35:0]       res_addr
);
  win_t [NUM_WIN-1:0]           wins;
  logic [NUM_WIN-1:0]           hits;
  logic [NUM_WIN-1:0][PG_W-1:0] diffs;

  adw_regs #(.NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP), .CFG_AW(CFG_AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .wins(wins)
  );

  adw_match #(.NUM_WIN(NUM_WIN)) u_match (
    .wins(wins), .ag(lk_addr[PA_W-1:GRAN_W]), .hits(hits), .diffs(diffs)
  );

  adw_select #(.NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP)) u_sel (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .wins(wins), .hits(hits), .diffs(diffs), .res_valid(res_valid),
    .res_hit(res_hit), .res_tgt(res_tgt), .res_attr(res_attr), .res_addr(res_addr)
  );
endmodule

// File: rtl/addr_window_unit_chk.sv
module addr_window_unit_chk #(
  parameter int NUM_WIN   = 20,
  parameter int NUM_REMAP = 8,
  parameter int CFG_AW    = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CFG_AW-1:0] cfg_addr,
  input logic [31:0]       cfg_rdata,
  input logic              lk_valid,
  input logic [35:0]       lk_addr,
  input logic              res_valid,
  input logic              res_hit,
  input logic [3:0]        res_tgt,
  input logic [7:0]        res_attr,
  input logic [35:0]       res_addr
);
  localparam int LO_END  = NUM_REMAP * 4;
  localparam int HI_BEG  = LO_END + 4;
  localparam int HI_END  = HI_BEG + (NUM_WIN - NUM_REMAP) * 2;

  int  wi;
  logic rsvd, rlo_sel, ctrl_sel;

  assign wi       = int'(cfg_addr[CFG_AW-1:2]);
  assign rsvd     = (wi >= LO_END && wi < HI_BEG) || (wi >= HI_END);
  assign rlo_sel  = (wi < LO_END) && (cfg_addr[3:2] == 2'b10);
  assign ctrl_sel = ((wi < LO_END) && (cfg_addr[3:2] == 2'b00)) ||
                    ((wi >= HI_BEG) && (wi < HI_END) && !cfg_addr[2]);

  AST_RES_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> res_valid); // R12
  AST_RES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !res_valid); // R12
  AST_MISS_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> (res_tgt == 4'h0 && res_attr == 8'h00)); // R11
  AST_MISS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> (res_addr == $past(lk_addr))); // R11
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsvd |-> (cfg_rdata == 32'h0)); // R6
  AST_RMPLO_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rlo_sel |-> (cfg_rdata[15:0] == 16'h0)); // R5
  AST_CTRL_GAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_sel |-> (cfg_rdata[3:1] == 3'b000)); // R2
endmodule

bind addr_window_unit addr_window_unit_chk #(
  .NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP), .CFG_AW(CFG_AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata),
  .lk_valid(lk_valid), .lk_addr(lk_addr), .res_valid(res_valid),
  .res_hit(res_hit), .res_tgt(res_tgt), .res_attr(res_attr), .res_addr(res_addr)
);

// File: tb/addr_window_unit_test.sv
module addr_window_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        lk_valid = 1'b0;
  logic [35:0] lk_addr = '0;
  logic        res_valid, res_hit;
  logic [3:0]  res_tgt;
  logic [7:0]  res_attr;
  logic [35:0] res_addr;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  typedef struct {
    int          due;
    logic        hit;
    logic [3:0]  tgt;
    logic [7:0]  attr;
    logic [35:0] addr;
    string       req;
  } exp_t;
  exp_t sb[$];

  addr_window_unit uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lk_valid(lk_valid),
    .lk_addr(lk_addr), .res_valid(res_valid), .res_hit(res_hit),
    .res_tgt(res_tgt), .res_attr(res_attr), .res_addr(res_addr)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string req);
    @(negedge clk);
    cfg_addr = a;
    #1;
    chk(cfg_rdata == e, req, "rdata", 64'(cfg_rdata), 64'(e));
  endtask

  task automatic look(input logic [35:0] a, input logic eh, input logic [3:0] et,
                      input logic [7:0] ea, input logic [35:0] eaddr, input string req);
    exp_t e;
    @(negedge clk);
    e.due = cyc + 1; e.hit = eh; e.tgt = et; e.attr = ea; e.addr = eaddr; e.req = req;
    sb.push_back(e);
    lk_valid = 1'b1; lk_addr = a;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  // Monitor: pops one expected item per valid result.
  always @(posedge clk) begin
    #2;
    if (rst_n && res_valid) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R12", "unexpected res_valid", 64'(1), 64'(0));
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(cyc == e.due, "R12", "result cycle", 64'(cyc), 64'(e.due));
        chk(res_hit == e.hit, e.req, "hit", 64'(res_hit), 64'(e.hit));
        chk(res_tgt == e.tgt, e.req, "tgt", 64'(res_tgt), 64'(e.tgt));
        chk(res_attr == e.attr, e.req, "attr", 64'(res_attr), 64'(e.attr));
        chk(res_addr == e.addr, e.req, "addr", 64'(res_addr), 64'(e.addr));
      end
    end
  end

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL R12 watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(res_valid == 1'b0, "R1", "res_valid", 64'(res_valid), 64'(0));
    rd(8'h00, 32'h0, "R1");
    rd(8'hE8, 32'h0, "R1");
    look(36'h0_1234_5678, 1'b0, 4'h0, 8'h00, 36'h0_1234_5678, "R1");

    // R2: control field layout and gap bits
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, 32'hFFFF_FFF1, "R2");
    wr(8'h00, 32'h0000_0000);
    rd(8'h00, 32'h0, "R2");

    // Window 2: remappable, 1 MiB at 0x1_4000_0000 -> 0x2_8000_0000
    wr(8'h24, 32'h4000_ABC1);
    rd(8'h24, 32'h4000_0001, "R3");
    wr(8'h20, 32'h000F_A351);
    rd(8'h20, 32'h000F_A351, "R2");
    wr(8'h28, 32'h8000_1234);
    rd(8'h28, 32'h8000_0000, "R5");
    wr(8'h2C, 32'hFFFF_FFF2);
    rd(8'h2C, 32'h0000_0002, "R5");

    look(36'h1_4001_2345, 1'b1, 4'h5, 8'hA3, 36'h2_8001_2345, "R9");
    look(36'h1_400F_FFFF, 1'b1, 4'h5, 8'hA3, 36'h2_800F_FFFF, "R7");
    look(36'h1_4010_0000, 1'b0, 4'h0, 8'h00, 36'h1_4010_0000, "R7");
    look(36'h1_3FFF_FFFF, 1'b0, 4'h0, 8'h00, 36'h1_3FFF_FFFF, "R11");
    look(36'h0_4001_2345, 1'b0, 4'h0, 8'h00, 36'h0_4001_2345, "R3");

    // Window 9: non-remappable, 64 KiB at 0xC000_0000 (control 0x98, base 0x9C)
    wr(8'h9C, 32'hC000_0000);
    wr(8'h98, 32'h0000_1EC1);
    rd(8'h98, 32'h0000_1EC1, "R4");
    rd(8'h9B, 32'h0000_1EC1, "R4");
    look(36'h0_C000_8000, 1'b1, 4'hC, 8'h1E, 36'h0_C000_8000, "R10");
    look(36'h0_C001_0000, 1'b0, 4'h0, 8'h00, 36'h0_C001_0000, "R7");

    // Window 5 overlaps window 9; remap words left zero
    wr(8'h54, 32'hC000_0000);
    wr(8'h50, 32'h0001_7731);
    look(36'h0_C000_8000, 1'b1, 4'h3, 8'h77, 36'h0_0000_8000, "R8");
    look(36'h0_C001_0000, 1'b1, 4'h3, 8'h77, 36'h0_0001_0000, "R9");
    wr(8'h50, 32'h0001_7730);
    look(36'h0_C000_8000, 1'b1, 4'hC, 8'h1E, 36'h0_C000_8000, "R7");
    look(36'h0_C001_0000, 1'b0, 4'h0, 8'h00, 36'h0_C001_0000, "R7");

    // R6: reserved hole and tail
    wr(8'h80, 32'hFFFF_FFFF);
    wr(8'h8C, 32'hFFFF_FFFF);
    wr(8'hF4, 32'hFFFF_FFFF);
    rd(8'h80, 32'h0, "R6");
    rd(8'h8C, 32'h0, "R6");
    rd(8'hF4, 32'h0, "R6");
    rd(8'h90, 32'h0, "R6");
    rd(8'h5C, 32'h0, "R6");
    look(36'h0_C000_8000, 1'b1, 4'hC, 8'h1E, 36'h0_C000_8000, "R6");

    // R4: last window of the upper stride
    wr(8'hE8, 32'h0000_0020);
    rd(8'hE8, 32'h0000_0020, "R4");
    rd(8'hE0, 32'h0, "R4");
    rd(8'hEC, 32'h0, "R4");

    repeat (4) @(negedge clk);
    chk(sb.size() == 0, "R12", "pending results", 64'(sb.size()), 64'(0));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule